// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

A memory-mapped watchdog timer that sits on a simple single-cycle register bus. An enable pulse at 32768 Hz feeds a programmable prescaler, and each prescaler step decrements a 16-bit down-counter. If the counter is running and reaches zero, the block latches a timeout flag and asserts a reset request. Both stay set until the active-low system reset.

Every bus write must carry the 16-bit key 0x1234 in the upper half of the write data. A write with a wrong key is dropped without a trace. Configuration and load writes land in shadow registers. They do nothing until the matching group of the refresh register is serviced. The refresh register holds three 2-bit groups, and a group is serviced by flipping it between 1 and 2. Software therefore programs the divisor and reload value, toggles the groups to commit them and reload the counter, and then sets the run bit. After that it keeps toggling the counter group within each timeout window. The timeout in seconds is reload value times divisor divided by 32768.

Top module: `kwdt_top`

## Requirements
- R1: After rst_ni, configuration reads 0x0F00 (divisor 16, interrupt value 0), the live counter reads 0xFFFF, refresh reads 0x0015, the start register reads 0, and timeout_o and rst_req_o are low.
- R2: A write whose wdata[31:16] differs from 0x1234 changes no register, no active setting and no counter.
- R3: Byte offsets: 0x04 configuration, 0x08 load (reads return the live counter), 0x18 refresh, 0x1C start. A request raises ready_o for exactly the following cycle. Read data appears in that cycle with bits 31:16 zero.
- R4: Configuration and load writes go to shadow registers. Configuration bits 15:8 (divisor minus one) and the load value become active only when refresh bits 5:4 change between 1 and 2.
- R5: Configuration bits 7:0 (interrupt value) become active only when refresh bits 1:0 change between 1 and 2.
- R6: A refresh write that leaves a group unchanged, writes 0 or 3 to it, or moves it away from 0 or 3 has no effect for that group.
- R7: A change between 1 and 2 of refresh bits 3:2 reloads the counter from the active load value and clears the prescaler phase. If the configuration group toggles in the same write, the newly committed load value is used.
- R8: With stored divisor field k, the counter decrements once every k+1 tick_i pulses while running. It does not go below zero.
- R9: Start bit 0 set lets ticks count. Clearing it halts counting and keeps the count.
- R10: While running with the counter at zero, timeout_o and rst_req_o rise on the next cycle. They stay high through reloads until rst_ni.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 32768 Hz tick enable, one cycle wide |
| bus_req_i | input | 1 | Bus request |
| bus_we_i | input | 1 | Write enable, qualifies bus_req_i |
| bus_addr_i | input | 5 | Byte address |
| bus_wdata_i | input | 32 | Write data: key in 31:16, data in 15:0 |
| bus_rdata_o | output | 32 | Read data, zero-extended 16-bit value |
| bus_ready_o | output | 1 | High the cycle after a request |
| timeout_o | output | 1 | Sticky expiry flag |
| rst_req_o | output | 1 | System reset request |

## Verification
The assertions assume that tick_i is a clean single-cycle enable and that requests are never backed up, because each transfer completes in one cycle. They also assume no reload happens in the cycle the flag is being latched. The bench drives ticks only from a dedicated task, with bus requests and ticks kept in separate cycles. Each scenario starts from a fresh reset, so no assertion window reaches across scenarios. A divisor of 1 or 3 keeps the expiry paths short while still exercising the phase clear on reload.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned BUS_W  = 32;
  localparam logic [DATA_W-1:0] WR_KEY = 16'h1234;

  localparam logic [7:0] OFS_CFG   = 8'h04;
  localparam logic [7:0] OFS_LOAD  = 8'h08;
  localparam logic [7:0] OFS_RFSH  = 8'h18;
  localparam logic [7:0] OFS_START = 8'h1C;

  localparam int unsigned N_GRP   = 3;
  localparam int unsigned GRP_IRQ = 0;
  localparam int unsigned GRP_CNT = 1;
  localparam int unsigned GRP_CFG = 2;

  localparam logic [DATA_W-1:0] RFSH_RST = 16'h0015;

  typedef enum logic [1:0] {
    SEL_CFG, SEL_LOAD, SEL_RFSH, SEL_START
  } reg_sel_e;
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              ready_o,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DIV_W-1:0]  div_m1_o,
  output logic              en_o,
  output logic              reload_o,
  output logic [CNT_W-1:0]  reload_val_o
);
  localparam int unsigned IRQ_W = DATA_W - DIV_W;

  logic [DATA_W-1:0] wval;
  logic              key_ok, wr_ok;
  logic              hit_cfg, hit_load, hit_rfsh, hit_start;

  logic [DATA_W-1:0] cfg_sh;
  logic [CNT_W-1:0]  load_sh, load_act;
  logic [DIV_W-1:0]  div_act;
  logic [IRQ_W-1:0]  irq_act;
  logic [DATA_W-1:0] rfsh_q;
  logic              en_q;
  logic [N_GRP-1:0]  tog;

  assign wval     = wdata_i[DATA_W-1:0];
  assign key_ok   = (wdata_i[BUS_W-1:DATA_W] == WR_KEY);
  assign wr_ok    = req_i && we_i && key_ok;
  assign hit_cfg   = (addr_i == OFS_CFG[ADDR_W-1:0]);
  assign hit_load  = (addr_i == OFS_LOAD[ADDR_W-1:0]);
  assign hit_rfsh  = (addr_i == OFS_RFSH[ADDR_W-1:0]);
  assign hit_start = (addr_i == OFS_START[ADDR_W-1:0]);

  // group fires only on a 1<->2 swap
  for (genvar g = 0; g < N_GRP; g++) begin : g_tog
    logic [1:0] old_v, new_v;
    assign old_v  = rfsh_q[2*g +: 2];
    assign new_v  = wval[2*g +: 2];
    assign tog[g] = wr_ok && hit_rfsh &&
                    ((old_v == 2'd1 && new_v == 2'd2) ||
                     (old_v == 2'd2 && new_v == 2'd1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_sh  <= {DIV_W'(16 - 1), IRQ_W'(0)};
      load_sh <= '1;
      rfsh_q  <= RFSH_RST;
      en_q    <= 1'b0;
    end else if (wr_ok) begin
      if (hit_cfg)   cfg_sh  <= wval;
      if (hit_load)  load_sh <= CNT_W'(wval);
      if (hit_rfsh)  rfsh_q  <= wval;
      if (hit_start) en_q    <= wval[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_act  <= DIV_W'(16 - 1);
      load_act <= '1;
      irq_act  <= '0;
    end else begin
      if (tog[GRP_CFG]) begin
        div_act  <= cfg_sh[DATA_W-1:IRQ_W];
        load_act <= load_sh;
      end
      if (tog[GRP_IRQ]) irq_act <= cfg_sh[IRQ_W-1:0];
    end
  end

  assign div_m1_o     = div_act;
  assign en_o         = en_q;
  assign reload_o     = tog[GRP_CNT];
  assign reload_val_o = tog[GRP_CFG] ? load_sh : load_act;

  reg_sel_e          sel;
  logic [DATA_W-1:0] rmux;

  always_comb begin
    sel = SEL_START;
    if (hit_cfg)       sel = SEL_CFG;
    else if (hit_load) sel = SEL_LOAD;
    else if (hit_rfsh) sel = SEL_RFSH;
    rmux = '0;
    unique case (sel)
      SEL_CFG:   rmux = {div_act, irq_act};
      SEL_LOAD:  rmux = DATA_W'(cnt_i);
      SEL_RFSH:  rmux = rfsh_q;
      SEL_START: rmux = hit_start ? DATA_W'(en_q) : '0;
      default:   rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      ready_o <= 1'b0;
    end else begin
      ready_o <= req_i;
      if (req_i && !we_i) rdata_o <= {{(BUS_W-DATA_W){1'b0}}, rmux};
    end
  end

  // R2: keyless writes leave settings untouched
  p_badkey_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !key_ok) |=>
      ($stable(div_act) && $stable(irq_act) && $stable(en_q) && $stable(rfsh_q)));

  // R3: one-cycle ready
  p_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ready_o);

  p_ready_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ready_o);

  // R6: configuration active only moves on a cfg-group swap
  p_cfg_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_ok && hit_rfsh) |=> $stable(div_act));
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [DIV_W-1:0] div_m1_i,
  output logic             step_o
);
  logic [DIV_W-1:0] phase_q;
  logic             wrap;

  // >= tolerates a divisor shrunk mid-phase
  assign wrap   = (phase_q >= div_m1_i);
  assign step_o = run_i && wrap && !clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       phase_q <= '0;
    else if (clear_i)  phase_q <= '0;
    else if (run_i)    phase_q <= wrap ? '0 : phase_q + 1'b1;
  end

  // R7: reload leaves phase at zero
  p_phase_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (phase_q == '0));

  // R9: no ticks, no phase motion
  p_phase_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clear_i) |=> $stable(phase_q));
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             exp_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '1;
    else if (reload_i)          cnt_q <= reload_val_i;
    else if (step_i && !at_zero) cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                exp_q <= 1'b0;
    else if (en_i && at_zero)   exp_q <= 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign expired_o = exp_q;

  // R10: sticky until reset
  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_q |=> exp_q);

  p_expire_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && at_zero) |=> exp_q);

  // R8: at most one count per cycle, never wraps
  p_dec_one_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload_i |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - 1'b1)));

  // R9: halted counter keeps its count
  p_halt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !reload_i) |=> $stable(cnt_q));
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              bus_ready_o,
  output logic              timeout_o,
  output logic              rst_req_o
);
  logic [DIV_W-1:0] div_m1;
  logic             en;
  logic             reload;
  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] cnt;
  logic             step;
  logic             expired;

  kwdt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (bus_req_i),
    .we_i         (bus_we_i),
    .addr_i       (bus_addr_i),
    .wdata_i      (bus_wdata_i),
    .rdata_o      (bus_rdata_o),
    .ready_o      (bus_ready_o),
    .cnt_i        (cnt),
    .div_m1_o     (div_m1),
    .en_o         (en),
    .reload_o     (reload),
    .reload_val_o (reload_val)
  );

  kwdt_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (en && tick_i),
    .clear_i  (reload),
    .div_m1_i (div_m1),
    .step_o   (step)
  );

  kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en),
    .reload_i     (reload),
    .reload_val_i (reload_val),
    .step_i       (step),
    .cnt_o        (cnt),
    .expired_o    (expired)
  );

  assign timeout_o = expired;
  assign rst_req_o = expired;
endmodule

// File: tb/kwdt_top_tb.sv
module kwdt_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready, tmo, rreq;
  int          n_run = 0, n_fail = 0;
  logic        done = 1'b0;

  localparam logic [4:0] A_CFG = 5'h04, A_LOAD = 5'h08, A_RF = 5'h18, A_ST = 5'h1C;
  localparam logic [15:0] KEY = 16'h1234;

  always #5 clk = ~clk;

  kwdt_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .bus_ready_o(ready), .timeout_o(tmo), .rst_req_o(rreq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; tick = 1'b0; req = 1'b0; we = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr_raw(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    wr_raw(a, {KEY, d});
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    chk("R1 timeout", {31'b0, tmo}, 32'd0);
    chk("R1 rst_req", {31'b0, rreq}, 32'd0);
    rd(A_CFG, v);  chk("R1 cfg", v, 32'h0F00);
    rd(A_LOAD, v); chk("R1 count", v, 32'hFFFF);
    rd(A_RF, v);   chk("R1 refresh", v, 32'h0015);
    rd(A_ST, v);   chk("R1 start", v, 32'h0);
  endtask

  task automatic t_bus();
    logic [31:0] v;
    do_reset();
    @(negedge clk); req = 1'b1; we = 1'b0; addr = A_CFG;
    @(negedge clk); req = 1'b0; v = rdata;
    chk("R3 ready after req", {31'b0, ready}, 32'd1);
    chk("R3 upper zero", v, 32'h0000_0F00);
    @(negedge clk);
    chk("R3 ready drops", {31'b0, ready}, 32'd0);
  endtask

  task automatic t_key();
    logic [31:0] v;
    do_reset();
    wr_raw(A_ST, 32'hABCD_0001);
    rd(A_ST, v);   chk("R2 start bad key", v, 32'h0);
    wr_raw(A_CFG, 32'h1235_0000);
    wr(A_RF, 16'h002A);
    rd(A_CFG, v);  chk("R2 cfg bad key", v, 32'h0F00);
    do_reset();
    wr_raw(A_RF, 32'h0000_002A);
    rd(A_RF, v);   chk("R2 refresh bad key", v, 32'h0015);
    rd(A_LOAD, v); chk("R2 count bad key", v, 32'hFFFF);
  endtask

  task automatic t_shadow();
    logic [31:0] v;
    do_reset();
    wr(A_CFG, 16'h0307);
    rd(A_CFG, v);  chk("R4 cfg shadowed", v, 32'h0F00);
    wr(A_LOAD, 16'h0009);
    rd(A_LOAD, v); chk("R4 load shadowed", v, 32'hFFFF);
    wr(A_RF, 16'h0035);
    rd(A_CFG, v);  chk("R6 to 3 no commit", v, 32'h0F00);
    rd(A_RF, v);   chk("R3 refresh readback", v, 32'h0035);
    wr(A_RF, 16'h0015);
    rd(A_CFG, v);  chk("R6 from 3 no commit", v, 32'h0F00);
    wr(A_RF, 16'h0015);
    rd(A_CFG, v);  chk("R6 unchanged no commit", v, 32'h0F00);
    wr(A_RF, 16'h0025);
    rd(A_CFG, v);  chk("R4 cfg commit", v, 32'h0300);
    rd(A_LOAD, v); chk("R7 no reload without cnt group", v, 32'hFFFF);
    wr(A_RF, 16'h0026);
    rd(A_CFG, v);  chk("R5 irq commit", v, 32'h0307);
    wr(A_RF, 16'h002A);
    rd(A_LOAD, v); chk("R7 reload", v, 32'h0009);
  endtask

  task automatic t_run_halt();
    logic [31:0] v;
    do_reset();
    wr(A_CFG, 16'h0000); wr(A_LOAD, 16'h0005); wr(A_RF, 16'h002A);
    rd(A_LOAD, v); chk("R7 combined reload", v, 32'h5);
    ticks(2);
    rd(A_LOAD, v); chk("R9 stopped before start", v, 32'h5);
    wr(A_ST, 16'h0001);
    ticks(2);
    rd(A_LOAD, v); chk("R9 running", v, 32'h3);
    wr(A_ST, 16'h0000);
    ticks(3);
    rd(A_LOAD, v); chk("R9 halt keeps count", v, 32'h3);
    rd(A_ST, v);   chk("R9 start readback", v, 32'h0);
    wr(A_ST, 16'h0001);
    ticks(3);
    chk("R10 not before next cycle", {31'b0, tmo}, 32'd0);
    @(negedge clk);
    chk("R10 timeout", {31'b0, tmo}, 32'd1);
    chk("R10 rst_req", {31'b0, rreq}, 32'd1);
    ticks(2);
    rd(A_LOAD, v); chk("R8 floor at zero", v, 32'h0);
    wr(A_RF, 16'h0026);
    rd(A_LOAD, v); chk("R7 reload after expiry", v, 32'h5);
    chk("R10 sticky after reload", {31'b0, tmo}, 32'd1);
    do_reset();
    chk("R10 cleared by reset", {31'b0, rreq}, 32'd0);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    do_reset();
    wr(A_CFG, 16'h0200); wr(A_LOAD, 16'h0004); wr(A_RF, 16'h002A);
    wr(A_ST, 16'h0001);
    ticks(5);
    rd(A_LOAD, v); chk("R8 divide by 3", v, 32'h3);
    ticks(1);
    rd(A_LOAD, v); chk("R8 second step", v, 32'h2);
    ticks(2);
    wr(A_RF, 16'h0026);
    ticks(2);
    rd(A_LOAD, v); chk("R7 phase cleared", v, 32'h4);
    ticks(1);
    rd(A_LOAD, v); chk("R7 full period after reload", v, 32'h3);
  endtask

  task automatic t_zero_load();
    do_reset();
    wr(A_CFG, 16'h0000); wr(A_LOAD, 16'h0000); wr(A_RF, 16'h002A);
    @(negedge clk); @(negedge clk);
    chk("R9 zero while stopped", {31'b0, tmo}, 32'd0);
    wr(A_ST, 16'h0001);
    @(negedge clk);
    chk("R10 zero load expires", {31'b0, tmo}, 32'd1);
  endtask

  initial begin
    t_reset();
    t_bus();
    t_key();
    t_shadow();
    t_run_halt();
    t_prescale();
    t_zero_load();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule